// File: doc/BRIEF.md
# Serial Channel Mode and Command Register File

This block is the byte-wide register front end of one channel of a two-channel UART. A CPU reaches it over a simple bus with a two-bit offset, a write strobe, a read strobe and separate write and read data. It holds the framing setup (data length, parity, stop code), the extended setup (FIFO enable, transmit ready level, extended baud table), a clock-select byte, the receiver and transmitter enables and the transmit break state. It also assembles a status byte from the serializer's level flags and its own sticky error flags. The serializer and the FIFOs sit outside. They take the enables, format fields and one-cycle flush, load and pop pulses from this block, and they return level flags and one-cycle event pulses.

The three mode registers share offset 0. An internal pointer chooses among them: a command loads the pointer, and each write through offset 0 advances it. Reads and writes at the same offset can reach different registers. Offset 1 reads status but writes the clock select. Offset 3 pops received data on a read and loads transmit data on a write. The command register at offset 2 carries four direct enable/disable bits plus a four-bit command code, and every part of one write is acted on together.

Top module: `sio_chan_regfile`

## Requirements
- R1: After reset: receiver and transmitter disabled, no break, mode pointer on MR1, MR1 = 0x13 (8 data bits, no parity), MR2 = 0x07 (one stop bit), MR0 = 0x00, clock select 0x00, all sticky status flags clear.
- R2: A write to offset 2 uses bit 0 to enable the receiver, bit 1 to disable it, bit 2 to enable the transmitter and bit 3 to disable it. When enable and disable are both set, disable wins. The command code in bits 7:4 of the same write is acted on in the same cycle.
- R3: Command code 1 points the mode pointer at MR1. Successive writes to offset 0 then go to MR1 and then to MR2, and further writes keep landing in MR2. A read at offset 0 returns the register the pointer selects and does not move the pointer.
- R4: With HAS_MR0 = 1, command code 0xB points at MR0. The next offset 0 write lands in MR0 (bit 3 FIFO enable, bit 4 half-level transmit ready, bits 2:0 extended baud select) and moves the pointer to MR1. With HAS_MR0 = 0 the code is ignored and the MR0 outputs stay 0.
- R5: MR1 bits 1:0 drive the data-length code (0..3 for 5..8 bits) and bits 4:2 drive the parity code (0 even, 1 odd, 4 none). MR2 bits 3:0 drive the stop code (7 one stop bit, 0xF two).
- R6: A write at offset 1 sets the clock-select byte. A read at offset 1 returns status: bit 0 receive ready, 1 receive FIFO full, 2 transmit ready, 3 transmitter empty, 4 overrun, 5 parity error, 6 framing error, 7 break received.
- R7: A write at offset 3 presents the byte on txData with a one-cycle txLoad pulse in the cycle after the write. A read at offset 3 returns rxHoldData and gives a one-cycle rxPop pulse in the cycle after the read.
- R8: Overrun, parity and framing status bits are sticky, set by their event pulses and cleared only by command code 4, which leaves the enables unchanged. An event in the same cycle as the clear stays set.
- R9: The break-received status bit is sticky. Command code 4 does not clear it; command code 5 does.
- R10: Command code 2 gives a one-cycle rxFlush pulse and hides receive ready and FIFO full in status until rxFifoReady has been low. Command code 3 gives a one-cycle txFlush pulse. Neither changes the enables.
- R11: Command code 6 starts a break (txBreak high, txLine low) if the transmitter is enabled after that write. Command code 7 ends it, and so does disabling the transmitter. With no break, txLine follows serTxd.
- R12: Status bits 2 and 3 report transmit ready and transmitter empty only while the transmitter is enabled, and read 0 otherwise.
- R13: busRdata changes only at a clock edge where busRd is sampled high, and holds its value otherwise. A read at offset 2 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | AW | Register offset within the channel |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | DW | Write data |
| busRdata | output | DW | Read data, registered |
| rxFifoReady | input | 1 | Receive FIFO holds data |
| rxFifoFull | input | 1 | Receive FIFO is full |
| txFifoReady | input | 1 | Transmit FIFO can accept data |
| txShiftEmpty | input | 1 | Transmitter fully idle |
| evOverrun | input | 1 | Overrun event pulse |
| evParity | input | 1 | Parity error event pulse |
| evFraming | input | 1 | Framing error event pulse |
| evBreak | input | 1 | Break received event pulse |
| rxHoldData | input | DW | Oldest received byte |
| serTxd | input | 1 | Serial output from the serializer |
| rxEnable | output | 1 | Receiver enable |
| txEnable | output | 1 | Transmitter enable |
| rxFlush | output | 1 | Receiver reset pulse |
| txFlush | output | 1 | Transmitter reset pulse |
| txBreak | output | 1 | Break active |
| txLine | output | 1 | Transmit line after break forcing |
| dataBits | output | 2 | Data length code |
| parityMode | output | 3 | Parity code |
| stopCode | output | 4 | Stop bit code |
| fifoEnable | output | 1 | FIFO enable |
| txHalfLevel | output | 1 | Half-full transmit ready level |
| baudExt | output | 3 | Extended baud table select |
| clockSel | output | DW | Clock select byte |
| txLoad | output | 1 | Transmit load pulse |
| txData | output | DW | Transmit byte |
| rxPop | output | 1 | Receive pop pulse |

## Verification
The bench builds two copies that share one bus: one with HAS_MR0 = 1 (DW = 8, AW = 2), which runs every check, and one with HAS_MR0 = 0. The second copy brings the ignored MR0 pointer command within reach. In that copy the same write sequence has to fall into MR2 and leave the FIFO setup at 0. The first copy covers pointer walks from both pointer commands, disable-wins and combined command writes, and a clear arriving in the same cycle as a new error event. It also covers the masked receive ready after a receiver reset and a break that ends when the transmitter is disabled.

// File: rtl/sio_regs_pkg.sv
`timescale 1ns/1ps
package sio_regs_pkg;

  // channel offsets (the CPU map depends on these)
  localparam int OFS_MODE = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CMD  = 2;
  localparam int OFS_HOLD = 3;

  // command codes carried in bits 7:4 of a command write
  localparam logic [3:0] CMD_PTR_MR1 = 4'h1;
  localparam logic [3:0] CMD_RST_RX  = 4'h2;
  localparam logic [3:0] CMD_RST_TX  = 4'h3;
  localparam logic [3:0] CMD_RST_ERR = 4'h4;
  localparam logic [3:0] CMD_RST_BRK = 4'h5;
  localparam logic [3:0] CMD_BRK_ON  = 4'h6;
  localparam logic [3:0] CMD_BRK_OFF = 4'h7;
  localparam logic [3:0] CMD_PTR_MR0 = 4'hB;

  localparam logic [7:0] MR0_RESET = 8'h00;
  localparam logic [7:0] MR1_RESET = 8'h13;
  localparam logic [7:0] MR2_RESET = 8'h07;

  typedef enum logic [1:0] {
    PTR_MR0 = 2'd0,
    PTR_MR1 = 2'd1,
    PTR_MR2 = 2'd2
  } modePtr_t;

  // strobes from control to datapath, one bus cycle wide
  typedef struct packed {
    logic wrMr0;
    logic wrMr1;
    logic wrMr2;
    logic wrClk;
    logic wrThr;
    logic rdMode;
    logic rdStat;
    logic rdCmd;
    logic rdHold;
    logic rxOn;
    logic rxOff;
    logic txOn;
    logic txOff;
    logic rstRx;
    logic rstTx;
    logic rstErr;
    logic rstBrk;
    logic brkOn;
    logic brkOff;
  } chanStrb_t;

endpackage

// File: rtl/sio_chan_ctrl.sv
`timescale 1ns/1ps
module sio_chan_ctrl
  import sio_regs_pkg::*;
#(
  parameter int AW      = 2,
  parameter int DW      = 8,
  parameter bit HAS_MR0 = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWr,
  input  logic          busRd,
  input  logic [DW-1:0] busWdata,
  output chanStrb_t     strb,
  output modePtr_t      modePtr
);

  localparam logic [AW-1:0] A_MODE = AW'(OFS_MODE);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CMD  = AW'(OFS_CMD);
  localparam logic [AW-1:0] A_HOLD = AW'(OFS_HOLD);

  modePtr_t   ptrQ;
  logic       wrMode;
  logic       wrCmd;
  logic [3:0] cmdCode;
  logic       ptrToMr1;
  logic       ptrToMr0;

  assign wrMode  = busWr && (busAddr == A_MODE);
  assign wrCmd   = busWr && (busAddr == A_CMD);
  assign cmdCode = busWdata[7:4];

  assign ptrToMr1 = wrCmd && (cmdCode == CMD_PTR_MR1);

  generate
    if (HAS_MR0) begin : g_ptrMr0
      assign ptrToMr0 = wrCmd && (cmdCode == CMD_PTR_MR0);
    end else begin : g_noPtrMr0
      assign ptrToMr0 = 1'b0;
    end
  endgenerate

  always_comb begin
    strb        = '0;
    strb.wrMr0  = wrMode && (ptrQ == PTR_MR0);
    strb.wrMr1  = wrMode && (ptrQ == PTR_MR1);
    strb.wrMr2  = wrMode && (ptrQ == PTR_MR2);
    strb.wrClk  = busWr && (busAddr == A_STAT);
    strb.wrThr  = busWr && (busAddr == A_HOLD);
    strb.rdMode = busRd && (busAddr == A_MODE);
    strb.rdStat = busRd && (busAddr == A_STAT);
    strb.rdCmd  = busRd && (busAddr == A_CMD);
    strb.rdHold = busRd && (busAddr == A_HOLD);
    strb.rxOn   = wrCmd && busWdata[0];
    strb.rxOff  = wrCmd && busWdata[1];
    strb.txOn   = wrCmd && busWdata[2];
    strb.txOff  = wrCmd && busWdata[3];
    strb.rstRx  = wrCmd && (cmdCode == CMD_RST_RX);
    strb.rstTx  = wrCmd && (cmdCode == CMD_RST_TX);
    strb.rstErr = wrCmd && (cmdCode == CMD_RST_ERR);
    strb.rstBrk = wrCmd && (cmdCode == CMD_RST_BRK);
    strb.brkOn  = wrCmd && (cmdCode == CMD_BRK_ON);
    strb.brkOff = wrCmd && (cmdCode == CMD_BRK_OFF);
  end

  // pointer: commands reload it, mode writes walk MR0 -> MR1 -> MR2 and park
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= PTR_MR1;
    end else if (ptrToMr1) begin
      ptrQ <= PTR_MR1;
    end else if (ptrToMr0) begin
      ptrQ <= PTR_MR0;
    end else if (wrMode) begin
      case (ptrQ)
        PTR_MR0: ptrQ <= PTR_MR1;
        PTR_MR1: ptrQ <= PTR_MR2;
        default: ptrQ <= PTR_MR2;
      endcase
    end
  end

  assign modePtr = ptrQ;

  // R3
  mr1_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMr1 |=> (modePtr == PTR_MR2));

  // R3
  mr2_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMr2 |=> (modePtr == PTR_MR2));

  // R4
  mr0_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMr0 |=> (modePtr == PTR_MR1));

endmodule

// File: rtl/sio_chan_data.sv
`timescale 1ns/1ps
module sio_chan_data
  import sio_regs_pkg::*;
#(
  parameter int DW      = 8,
  parameter bit HAS_MR0 = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  chanStrb_t     strb,
  input  modePtr_t      modePtr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic          rxFifoReady,
  input  logic          rxFifoFull,
  input  logic          txFifoReady,
  input  logic          txShiftEmpty,
  input  logic          evOverrun,
  input  logic          evParity,
  input  logic          evFraming,
  input  logic          evBreak,
  input  logic [DW-1:0] rxHoldData,
  input  logic          serTxd,
  output logic          rxEnable,
  output logic          txEnable,
  output logic          rxFlush,
  output logic          txFlush,
  output logic          txBreak,
  output logic          txLine,
  output logic [1:0]    dataBits,
  output logic [2:0]    parityMode,
  output logic [3:0]    stopCode,
  output logic          fifoEnable,
  output logic          txHalfLevel,
  output logic [2:0]    baudExt,
  output logic [DW-1:0] clockSel,
  output logic          txLoad,
  output logic [DW-1:0] txData,
  output logic          rxPop
);

  logic [7:0]    mr0Q, mr1Q, mr2Q;
  logic [DW-1:0] clkSelQ, txDataQ, rdataQ, rdataD;
  logic          rxEnQ, txEnQ, brkQ;
  logic          rxEnD, txEnD, brkD;
  logic          ovrQ, parQ, frmQ, brkDetQ;
  logic          rxHideQ;
  logic          rxFlushQ, txFlushQ, txLoadQ, rxPopQ;
  logic [7:0]    statVec;

  // ---- extended mode register, present only in the MR0 variant ----
  generate
    if (HAS_MR0) begin : g_mr0
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           mr0Q <= MR0_RESET;
        else if (strb.wrMr0) mr0Q <= busWdata[7:0];
      end
    end else begin : g_noMr0
      assign mr0Q = 8'h00;
    end
  endgenerate

  // ---- framing mode registers and clock select ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mr1Q    <= MR1_RESET;
      mr2Q    <= MR2_RESET;
      clkSelQ <= '0;
    end else begin
      if (strb.wrMr1) mr1Q    <= busWdata[7:0];
      if (strb.wrMr2) mr2Q    <= busWdata[7:0];
      if (strb.wrClk) clkSelQ <= busWdata;
    end
  end

  // ---- enables and break: disable wins, break needs an enabled transmitter ----
  always_comb begin
    rxEnD = rxEnQ;
    if (strb.rxOn)  rxEnD = 1'b1;
    if (strb.rxOff) rxEnD = 1'b0;
    txEnD = txEnQ;
    if (strb.txOn)  txEnD = 1'b1;
    if (strb.txOff) txEnD = 1'b0;
    brkD = brkQ;
    if (strb.brkOn) brkD = 1'b1;
    if (strb.brkOff || !txEnD) brkD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnQ <= 1'b0;
      txEnQ <= 1'b0;
      brkQ  <= 1'b0;
    end else begin
      rxEnQ <= rxEnD;
      txEnQ <= txEnD;
      brkQ  <= brkD;
    end
  end

  // ---- sticky status: a new event outranks a clear in the same cycle ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrQ    <= 1'b0;
      parQ    <= 1'b0;
      frmQ    <= 1'b0;
      brkDetQ <= 1'b0;
      rxHideQ <= 1'b0;
    end else begin
      ovrQ    <= (ovrQ    & ~strb.rstErr) | evOverrun;
      parQ    <= (parQ    & ~strb.rstErr) | evParity;
      frmQ    <= (frmQ    & ~strb.rstErr) | evFraming;
      brkDetQ <= (brkDetQ & ~strb.rstBrk) | evBreak;
      if (strb.rstRx)       rxHideQ <= 1'b1;
      else if (!rxFifoReady) rxHideQ <= 1'b0;
    end
  end

  // ---- one-cycle pulses toward the serializer and FIFOs ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFlushQ <= 1'b0;
      txFlushQ <= 1'b0;
      txLoadQ  <= 1'b0;
      rxPopQ   <= 1'b0;
      txDataQ  <= '0;
    end else begin
      rxFlushQ <= strb.rstRx;
      txFlushQ <= strb.rstTx;
      txLoadQ  <= strb.wrThr;
      rxPopQ   <= strb.rdHold;
      if (strb.wrThr) txDataQ <= busWdata;
    end
  end

  // ---- status byte ----
  always_comb begin
    statVec    = 8'h00;
    statVec[0] = rxFifoReady  & ~rxHideQ;
    statVec[1] = rxFifoFull   & ~rxHideQ;
    statVec[2] = txFifoReady  & txEnQ;
    statVec[3] = txShiftEmpty & txEnQ;
    statVec[4] = ovrQ;
    statVec[5] = parQ;
    statVec[6] = frmQ;
    statVec[7] = brkDetQ;
  end

  // ---- registered read-back ----
  always_comb begin
    rdataD = rdataQ;
    if (strb.rdMode) begin
      case (modePtr)
        PTR_MR0: rdataD = DW'(mr0Q);
        PTR_MR1: rdataD = DW'(mr1Q);
        default: rdataD = DW'(mr2Q);
      endcase
    end else if (strb.rdStat) begin
      rdataD = DW'(statVec);
    end else if (strb.rdCmd) begin
      rdataD = '0;
    end else if (strb.rdHold) begin
      rdataD = rxHoldData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else       rdataQ <= rdataD;
  end

  assign busRdata    = rdataQ;
  assign rxEnable    = rxEnQ;
  assign txEnable    = txEnQ;
  assign txBreak     = brkQ;
  assign txLine      = serTxd & ~brkQ;
  assign rxFlush     = rxFlushQ;
  assign txFlush     = txFlushQ;
  assign txLoad      = txLoadQ;
  assign txData      = txDataQ;
  assign rxPop       = rxPopQ;
  assign dataBits    = mr1Q[1:0];
  assign parityMode  = mr1Q[4:2];
  assign stopCode    = mr2Q[3:0];
  assign baudExt     = mr0Q[2:0];
  assign fifoEnable  = mr0Q[3];
  assign txHalfLevel = mr0Q[4];
  assign clockSel    = clkSelQ;

  // R2
  rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxOff |=> !rxEnable);

  // R11
  brk_needs_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBreak |-> txEnable);

  // R11
  brk_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBreak |-> !txLine);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rstErr && !evOverrun && !evParity && !evFraming)
      |=> (!ovrQ && !parQ && !frmQ));

  // R10
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rstRx |=> (rxFlush && $stable(rxEnable)));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdMode || strb.rdStat || strb.rdCmd || strb.rdHold) |=> $stable(busRdata));

endmodule

// File: rtl/sio_chan_regfile.sv
`timescale 1ns/1ps
module sio_chan_regfile
  import sio_regs_pkg::*;
#(
  parameter int AW      = 2,
  parameter int DW      = 8,
  parameter bit HAS_MR0 = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWr,
  input  logic          busRd,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic          rxFifoReady,
  input  logic          rxFifoFull,
  input  logic          txFifoReady,
  input  logic          txShiftEmpty,
  input  logic          evOverrun,
  input  logic          evParity,
  input  logic          evFraming,
  input  logic          evBreak,
  input  logic [DW-1:0] rxHoldData,
  input  logic          serTxd,
  output logic          rxEnable,
  output logic          txEnable,
  output logic          rxFlush,
  output logic          txFlush,
  output logic          txBreak,
  output logic          txLine,
  output logic [1:0]    dataBits,
  output logic [2:0]    parityMode,
  output logic [3:0]    stopCode,
  output logic          fifoEnable,
  output logic          txHalfLevel,
  output logic [2:0]    baudExt,
  output logic [DW-1:0] clockSel,
  output logic          txLoad,
  output logic [DW-1:0] txData,
  output logic          rxPop
);

  chanStrb_t strb;
  modePtr_t  modePtr;

  sio_chan_ctrl #(.AW(AW), .DW(DW), .HAS_MR0(HAS_MR0)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .strb     (strb),
    .modePtr  (modePtr)
  );

  sio_chan_data #(.DW(DW), .HAS_MR0(HAS_MR0)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .modePtr      (modePtr),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .rxFifoReady  (rxFifoReady),
    .rxFifoFull   (rxFifoFull),
    .txFifoReady  (txFifoReady),
    .txShiftEmpty (txShiftEmpty),
    .evOverrun    (evOverrun),
    .evParity     (evParity),
    .evFraming    (evFraming),
    .evBreak      (evBreak),
    .rxHoldData   (rxHoldData),
    .serTxd       (serTxd),
    .rxEnable     (rxEnable),
    .txEnable     (txEnable),
    .rxFlush      (rxFlush),
    .txFlush      (txFlush),
    .txBreak      (txBreak),
    .txLine       (txLine),
    .dataBits     (dataBits),
    .parityMode   (parityMode),
    .stopCode     (stopCode),
    .fifoEnable   (fifoEnable),
    .txHalfLevel  (txHalfLevel),
    .baudExt      (baudExt),
    .clockSel     (clockSel),
    .txLoad       (txLoad),
    .txData       (txData),
    .rxPop        (rxPop)
  );

endmodule

// File: tb/sio_chan_regfile_bench.sv
`timescale 1ns/1ps
module sio_chan_regfile_bench;

  localparam int AW = 2;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic rxFifoReady = 1'b0, rxFifoFull = 1'b0, txFifoReady = 1'b1, txShiftEmpty = 1'b1;
  logic evOverrun = 1'b0, evParity = 1'b0, evFraming = 1'b0, evBreak = 1'b0;
  logic [DW-1:0] rxHoldData = '0;
  logic serTxd = 1'b1;

  logic [DW-1:0] busRdata, clockSel, txData;
  logic rxEnable, txEnable, rxFlush, txFlush, txBreak, txLine;
  logic [1:0] dataBits; logic [2:0] parityMode; logic [3:0] stopCode;
  logic fifoEnable, txHalfLevel, txLoad, rxPop; logic [2:0] baudExt;

  logic [DW-1:0] nmRdata, nmClockSel, nmTxData;
  logic nmRxEn, nmTxEn, nmRxFlush, nmTxFlush, nmBrk, nmLine;
  logic [1:0] nmDataBits; logic [2:0] nmParity; logic [3:0] nmStop;
  logic nmFifo, nmHalf, nmTxLoad, nmRxPop; logic [2:0] nmBaud;

  always #2.5 clk = ~clk;

  sio_chan_regfile #(.AW(AW), .DW(DW), .HAS_MR0(1'b1)) u_sio_chan_regfile (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxFifoReady(rxFifoReady),
    .rxFifoFull(rxFifoFull), .txFifoReady(txFifoReady), .txShiftEmpty(txShiftEmpty),
    .evOverrun(evOverrun), .evParity(evParity), .evFraming(evFraming), .evBreak(evBreak),
    .rxHoldData(rxHoldData), .serTxd(serTxd), .rxEnable(rxEnable), .txEnable(txEnable),
    .rxFlush(rxFlush), .txFlush(txFlush), .txBreak(txBreak), .txLine(txLine),
    .dataBits(dataBits), .parityMode(parityMode), .stopCode(stopCode),
    .fifoEnable(fifoEnable), .txHalfLevel(txHalfLevel), .baudExt(baudExt),
    .clockSel(clockSel), .txLoad(txLoad), .txData(txData), .rxPop(rxPop)
  );

  sio_chan_regfile #(.AW(AW), .DW(DW), .HAS_MR0(1'b0)) u_sio_chan_regfile_nomr0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(nmRdata), .rxFifoReady(rxFifoReady),
    .rxFifoFull(rxFifoFull), .txFifoReady(txFifoReady), .txShiftEmpty(txShiftEmpty),
    .evOverrun(evOverrun), .evParity(evParity), .evFraming(evFraming), .evBreak(evBreak),
    .rxHoldData(rxHoldData), .serTxd(serTxd), .rxEnable(nmRxEn), .txEnable(nmTxEn),
    .rxFlush(nmRxFlush), .txFlush(nmTxFlush), .txBreak(nmBrk), .txLine(nmLine),
    .dataBits(nmDataBits), .parityMode(nmParity), .stopCode(nmStop),
    .fifoEnable(nmFifo), .txHalfLevel(nmHalf), .baudExt(nmBaud),
    .clockSel(nmClockSel), .txLoad(nmTxLoad), .txData(nmTxData), .rxPop(nmRxPop)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  logic [DW-1:0] expQ[$];
  string tagQ[$];
  logic rdSeen = 1'b0;
  logic [DW-1:0] popExp;
  string popTag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each completed read against the scoreboard queue
  always @(posedge clk) rdSeen <= busRd;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        popExp = expQ.pop_front();
        popTag = tagQ.pop_front();
        chk(popTag, 32'(busRdata), 32'(popExp));
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic pulseEv(input logic ov, input logic pe, input logic fe, input logic bk);
    @(negedge clk);
    evOverrun = ov; evParity = pe; evFraming = fe; evBreak = bk;
    @(negedge clk);
    evOverrun = 1'b0; evParity = 1'b0; evFraming = 1'b0; evBreak = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 rxEnable", rxEnable, 0);
    chk("R1 txEnable", txEnable, 0);
    chk("R1 txBreak", txBreak, 0);
    chk("R1 dataBits", dataBits, 3);
    chk("R1 parityMode", parityMode, 4);
    chk("R1 stopCode", stopCode, 7);
    chk("R1 fifoEnable", fifoEnable, 0);
    chk("R1 clockSel", clockSel, 0);
    rd(1, 8'h00, "R1 status after reset");
    rd(0, 8'h13, "R1 pointer on MR1");

    // R2 enables; R12 tx flags visible once enabled
    wr(2, 8'h05);
    chk("R2 rx enabled", rxEnable, 1);
    chk("R2 tx enabled", txEnable, 1);
    rd(1, 8'h0C, "R12 tx ready/empty when enabled");

    // R3 / R5 pointer walk and field mapping
    wr(2, 8'h10);
    wr(0, 8'h06);
    chk("R5 dataBits", dataBits, 2);
    chk("R5 parity odd", parityMode, 1);
    wr(0, 8'h0F);
    chk("R5 two stop", stopCode, 4'hF);
    wr(0, 8'h07);
    chk("R3 parked MR2 stop", stopCode, 7);
    chk("R3 MR1 untouched", dataBits, 2);
    rd(0, 8'h07, "R3 read MR2");
    rd(0, 8'h07, "R3 read does not advance");

    // R4 MR0 path
    wr(2, 8'hB0);
    rd(0, 8'h00, "R4 read MR0");
    wr(0, 8'h19);
    chk("R4 fifoEnable", fifoEnable, 1);
    chk("R4 txHalfLevel", txHalfLevel, 1);
    chk("R4 baudExt", baudExt, 1);
    wr(0, 8'h04);
    chk("R4 after MR0 goes MR1 bits", dataBits, 0);
    chk("R4 after MR0 goes MR1 parity", parityMode, 1);
    chk("R4 no-MR0 variant stop", nmStop, 4);
    chk("R4 no-MR0 variant fifo", nmFifo, 0);
    chk("R4 no-MR0 variant dataBits", nmDataBits, 2);

    // R6 clock select
    wr(1, 8'hBB);
    chk("R6 clockSel", clockSel, 8'hBB);

    // R7 holding register
    wr(3, 8'h5A);
    chk("R7 txLoad pulse", txLoad, 1);
    chk("R7 txData", txData, 8'h5A);
    tick();
    chk("R7 txLoad ends", txLoad, 0);
    rxHoldData = 8'hC3;
    rd(3, 8'hC3, "R7 rx hold read");
    chk("R7 rxPop pulse", rxPop, 1);
    tick();
    chk("R7 rxPop ends", rxPop, 0);

    // R8 sticky errors
    pulseEv(1, 0, 0, 0);
    rd(1, 8'h1C, "R8 overrun sticky");
    pulseEv(0, 1, 1, 0);
    rd(1, 8'h7C, "R8 parity framing sticky");
    wr(2, 8'h40);
    rd(1, 8'h0C, "R8 cleared");
    chk("R8 enables kept rx", rxEnable, 1);
    chk("R8 enables kept tx", txEnable, 1);
    @(negedge clk);
    evFraming = 1'b1; busAddr = 2; busWdata = 8'h40; busWr = 1'b1;
    @(negedge clk);
    evFraming = 1'b0; busWr = 1'b0;
    rd(1, 8'h4C, "R8 event beats clear");
    wr(2, 8'h40);

    // R9 break received
    pulseEv(0, 0, 0, 1);
    rd(1, 8'h8C, "R9 break sticky");
    wr(2, 8'h40);
    rd(1, 8'h8C, "R9 survives error clear");
    wr(2, 8'h50);
    rd(1, 8'h0C, "R9 break clear");

    // R10 receiver and transmitter reset
    rxFifoReady = 1'b1; rxFifoFull = 1'b1;
    rd(1, 8'h0F, "R6 rx ready and full");
    wr(2, 8'h20);
    chk("R10 rxFlush", rxFlush, 1);
    rd(1, 8'h0C, "R10 rx flags hidden");
    chk("R10 rx still enabled", rxEnable, 1);
    rxFifoReady = 1'b0; rxFifoFull = 1'b0;
    tick();
    rxFifoReady = 1'b1;
    rd(1, 8'h0D, "R10 rx ready returns");
    wr(2, 8'h30);
    chk("R10 txFlush", txFlush, 1);
    chk("R10 tx still enabled", txEnable, 1);

    // R11 break
    wr(2, 8'h60);
    chk("R11 break on", txBreak, 1);
    chk("R11 line low", txLine, 0);
    wr(2, 8'h70);
    chk("R11 break off", txBreak, 0);
    chk("R11 line follows", txLine, 1);
    wr(2, 8'h60);
    wr(2, 8'h08);
    chk("R11 tx disable ends break", txBreak, 0);
    chk("R11 tx disabled", txEnable, 0);
    chk("R11 line released", txLine, 1);
    rd(1, 8'h01, "R12 tx flags hidden when disabled");
    wr(2, 8'h60);
    chk("R11 no break while disabled", txBreak, 0);

    // R2 combined writes and disable priority
    wr(2, 8'h64);
    chk("R2 enable plus break", txBreak, 1);
    chk("R2 enable plus break tx", txEnable, 1);
    wr(2, 8'h0F);
    chk("R2 disable wins rx", rxEnable, 0);
    chk("R2 disable wins tx", txEnable, 0);
    chk("R2 break ends", txBreak, 0);

    // R13 read-back
    rd(2, 8'h00, "R13 command reads zero");
    rd(1, 8'h01, "R13 status before hold");
    repeat (3) tick();
    chk("R13 rdata held", busRdata, 8'h01);

    repeat (2) tick();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule